// File: doc/BRIEF.md
# Five-Stage Pipelined Load/Store Datapath

This block is an in-order, five-stage pipelined datapath for a small 32-bit load/store instruction subset. The stages run in this order: fetch, decode with register read, execute or address calculation, data memory access, and write-back. A pipeline register sits between each pair of stages. It carries the operands, immediates, destination number and control fields that later stages still need.

Control is decoded once, in the decode stage, into three groups. The execute group, the memory group and the write-back group ride down the pipeline with their instruction. Each group is consumed in its own stage and is then dropped from the pipeline registers that follow. The block has no hazard detection, no forwarding, no stalls and no flushes. Software must place at least two other instructions between a register write and a read of that register. The three instructions fetched after a branch always complete.

Instruction and data memories are small internal word arrays. A preload port writes them, normally while reset is held. Results are observed at a write-back port, a store port and the program counter output.

Top module: `pipe5_core`

## Requirements
- R1: An instruction fetched on clock edge k shows up at the write-back port after edge k+4. Once the pipe is full, one instruction retires per cycle. Without a taken branch, pc_o grows by 4 on every edge.
- R2: Loads (opcode 100011) write the register named in instruction bits 20-16. R-type instructions (opcode 000000) write the register named in bits 15-11. The number travels with its instruction to write-back.
- R3: Loads and stores (opcode 101011) form their byte address as the value of register bits 25-21 plus the sign-extended bits 15-0. R-type and branch use the register named in bits 20-16 as the second ALU operand.
- R4: R-type function codes 100000, 100010, 100100 and 100101 produce add, subtract, AND and OR, each modulo 2^32. Loads and stores add.
- R5: A branch on equality (opcode 000100) compares its two source registers by subtraction and resolves in the memory stage. When taken, pc_o becomes pc+4 of the branch plus the sign-extended offset times 4, on the fourth edge after the branch was fetched. The three instructions fetched behind it still complete.
- R6: A load writes back the data memory word. An R-type instruction writes back the ALU result.
- R7: Only a store asserts st_we_o, and it does so during its memory stage, with the address and the stored register value. A later load of that word returns the stored value.
- R8: Register 0 reads as zero even after an instruction targets it. A read in the same cycle as a write to that register returns the new value.
- R9: While reset is held and until the first results are due, pc_o is 0 and wb_we_o and st_we_o stay low.
- R10: Any other opcode, or any other R-type function code, writes neither a register nor memory.
- R11: With ld_en high, ld_data is written to word ld_addr of data memory when ld_dmem is 1 and of instruction memory when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | LAW | Preload word address |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current fetch address |
| wb_we_o | output | 1 | Write-back stage writes a register |
| wb_rd_o | output | 5 | Write-back destination register |
| wb_data_o | output | 32 | Write-back value |
| st_we_o | output | 1 | Memory stage performs a store |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The bench numbers fetch slots from the first edge after reset is released. It expects the result of slot s on the write-back port after edge s+4, and its store on the store port after edge s+3. The fetch address after edge c must equal the address its own model assigns to slot c, and this includes the redirect that appears four edges after a taken branch is fetched. Every value is sampled on the falling edge that follows the counted rising edge. A sequential reference model that knows about the three shadow slots of a branch supplies each expected value.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD    = 6'h20;
  localparam logic [5:0] FN_SUB    = 6'h22;
  localparam logic [5:0] FN_AND    = 6'h24;
  localparam logic [5:0] FN_OR     = 6'h25;

  typedef enum logic [1:0] {AC_ADD = 2'd0, AC_SUB = 2'd1, AC_FUNCT = 2'd2} alu_class_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    logic       dst_rd;
    logic       use_imm;
    alu_class_e aclass;
  } ex_ctl_t;

  typedef struct packed {
    logic rd_en;
    logic wr_en;
    logic is_beq;
  } mem_ctl_t;

  typedef struct packed {
    logic reg_we;
    logic from_mem;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ctl_t;

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } ifid_t;

  typedef struct packed {
    ctl_t            ctl;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] a_val;
    logic [XLEN-1:0] b_val;
    logic [XLEN-1:0] imm;
    logic [4:0]      rt;
    logic [4:0]      rd;
    logic [5:0]      funct;
  } idex_t;

  typedef struct packed {
    mem_ctl_t        mem;
    wb_ctl_t         wb;
    logic [XLEN-1:0] br_target;
    logic            zero;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] st_val;
    logic [4:0]      dst;
  } exmem_t;

  typedef struct packed {
    wb_ctl_t         wb;
    logic [XLEN-1:0] mem_data;
    logic [XLEN-1:0] alu_y;
    logic [4:0]      dst;
  } memwb_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic alu_op_e alu_select(input alu_class_e cls, input logic [5:0] fn);
    case (cls)
      AC_ADD:  return ALU_ADD;
      AC_SUB:  return ALU_SUB;
      default: begin
        case (fn)
          FN_SUB:  return ALU_SUB;
          FN_AND:  return ALU_AND;
          FN_OR:   return ALU_OR;
          default: return ALU_ADD;
        endcase
      end
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [XLEN-1:0] imm);
    return pc4 + {imm[XLEN-3:0], 2'b00};
  endfunction
endpackage

// File: rtl/pipe5_ctl_dec.sv
module pipe5_ctl_dec
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  logic fn_known;
  assign fn_known = (funct == FN_ADD) || (funct == FN_SUB) ||
                    (funct == FN_AND) || (funct == FN_OR);

  always_comb begin
    ctl = '0;
    case (opcode)
      OPC_RTYPE: if (fn_known) begin
        ctl.ex.dst_rd    = 1'b1;
        ctl.ex.aclass    = AC_FUNCT;
        ctl.wb.reg_we    = 1'b1;
      end
      OPC_LW: begin
        ctl.ex.use_imm   = 1'b1;
        ctl.ex.aclass    = AC_ADD;
        ctl.mem.rd_en    = 1'b1;
        ctl.wb.reg_we    = 1'b1;
        ctl.wb.from_mem  = 1'b1;
      end
      OPC_SW: begin
        ctl.ex.use_imm   = 1'b1;
        ctl.ex.aclass    = AC_ADD;
        ctl.mem.wr_en    = 1'b1;
      end
      OPC_BEQ: begin
        ctl.ex.aclass    = AC_SUB;
        ctl.mem.is_beq   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int NREAD  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [4:0]              waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [NREAD-1:0][4:0]   raddr,
  output logic [NREAD-1:0][XLEN-1:0] rdata
);
  logic [XLEN-1:0] regs [NREG];
  logic            wr_live;
  assign wr_live = we && (waddr != 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == 5'd0)                 rdata[p] = '0;
      else if (wr_live && waddr == raddr[p]) rdata[p] = wdata;
      else                                  rdata[p] = regs[raddr[p]];
    end

    assert_r0_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (raddr[p] == 5'd0) |-> (rdata[p] == '0));
    assert_same_cycle_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == raddr[p] && waddr != 5'd0) |-> (rdata[p] == wdata));
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  alu_class_e      aclass,
  input  logic [5:0]      funct,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  alu_op_e op;
  assign op   = alu_select(aclass, funct);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            ld_dmem,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [31:0]     ld_data,
  output logic [31:0]     pc_o,
  output logic            wb_we_o,
  output logic [4:0]      wb_rd_o,
  output logic [31:0]     wb_data_o,
  output logic            st_we_o,
  output logic [31:0]     st_addr_o,
  output logic [31:0]     st_data_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q;
  ifid_t  ifid_q;
  idex_t  idex_q;
  exmem_t exmem_q;
  memwb_t memwb_q;

  // Fetch
  logic [XLEN-1:0] f_instr, f_pc4;
  logic            br_take;
  assign f_instr = imem[pc_q[IAW+1:2]];
  assign f_pc4   = pc_q + 32'd4;
  assign br_take = exmem_q.mem.is_beq && exmem_q.zero;

  // Decode
  ctl_t                 d_ctl;
  logic [1:0][4:0]      d_raddr;
  logic [1:0][XLEN-1:0] d_rdata;
  assign d_raddr[0] = ifid_q.instr[25:21];
  assign d_raddr[1] = ifid_q.instr[20:16];

  pipe5_ctl_dec u_dec (
    .opcode (ifid_q.instr[31:26]),
    .funct  (ifid_q.instr[5:0]),
    .ctl    (d_ctl)
  );

  logic            w_we;
  logic [XLEN-1:0] w_data;

  pipe5_regfile #(.NREG(32), .NREAD(2)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (w_we),
    .waddr (memwb_q.dst),
    .wdata (w_data),
    .raddr (d_raddr),
    .rdata (d_rdata)
  );

  // Execute
  logic [XLEN-1:0] e_b, e_y;
  logic            e_zero;
  assign e_b = idex_q.ctl.ex.use_imm ? idex_q.imm : idex_q.b_val;

  pipe5_alu u_alu (
    .aclass (idex_q.ctl.ex.aclass),
    .funct  (idex_q.funct),
    .a      (idex_q.a_val),
    .b      (e_b),
    .y      (e_y),
    .zero   (e_zero)
  );

  // Memory
  logic [DAW-1:0]  m_idx;
  logic [XLEN-1:0] m_rdata;
  assign m_idx   = exmem_q.alu_y[DAW+1:2];
  assign m_rdata = exmem_q.mem.rd_en ? dmem[m_idx] : '0;

  // Write-back
  assign w_we   = memwb_q.wb.reg_we;
  assign w_data = memwb_q.wb.from_mem ? memwb_q.mem_data : memwb_q.alu_y;

  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
    if (ld_en && ld_dmem)          dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (exmem_q.mem.wr_en)    dmem[m_idx] <= exmem_q.st_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q   <= br_take ? exmem_q.br_target : f_pc4;
      ifid_q <= '{pc4: f_pc4, instr: f_instr};
      idex_q <= '{ctl: d_ctl, pc4: ifid_q.pc4, a_val: d_rdata[0], b_val: d_rdata[1],
                  imm: sext16(ifid_q.instr[15:0]), rt: ifid_q.instr[20:16],
                  rd: ifid_q.instr[15:11], funct: ifid_q.instr[5:0]};
      exmem_q <= '{mem: idex_q.ctl.mem, wb: idex_q.ctl.wb,
                   br_target: branch_dest(idex_q.pc4, idex_q.imm), zero: e_zero,
                   alu_y: e_y, st_val: idex_q.b_val,
                   dst: idex_q.ctl.ex.dst_rd ? idex_q.rd : idex_q.rt};
      memwb_q <= '{wb: exmem_q.wb, mem_data: m_rdata, alu_y: exmem_q.alu_y,
                   dst: exmem_q.dst};
    end
  end

  assign pc_o      = pc_q;
  assign wb_we_o   = w_we;
  assign wb_rd_o   = memwb_q.dst;
  assign wb_data_o = w_data;
  assign st_we_o   = exmem_q.mem.wr_en;
  assign st_addr_o = exmem_q.alu_y;
  assign st_data_o = exmem_q.st_val;

  assert_reset_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wb_we_o && !st_we_o && pc_o == '0));
  assert_branch_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> (pc_o == $past(exmem_q.br_target)));
  assert_seq_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_take && !$rose(rst_n)) |=> (pc_o == $past(pc_o) + 32'd4));
  assert_mem_uses_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_q.ctl.mem.rd_en || idex_q.ctl.mem.wr_en) |-> (e_y == idex_q.a_val + idex_q.imm));
  assert_mem_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(exmem_q.mem.rd_en && exmem_q.mem.wr_en));
  assert_dst_travels_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we_o && !$rose(rst_n)) |-> (wb_rd_o == $past(exmem_q.dst)));
endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0, ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        wb_we_o, st_we_o;
  logic [4:0]  wb_rd_o;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .wb_we_o(wb_we_o), .wb_rd_o(wb_rd_o),
    .wb_data_o(wb_data_o), .st_we_o(st_we_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  logic [31:0] prog [64];
  logic [31:0] dinit [64];
  logic [31:0] exp_pc [0:127];
  logic        exp_we [0:127];
  logic [4:0]  exp_rd [0:127];
  logic [31:0] exp_wd [0:127];
  logic        exp_ld [0:127];
  logic        exp_sw [0:127];
  logic [31:0] exp_sa [0:127];
  logic [31:0] exp_sd [0:127];
  logic [31:0] got_wd [0:127];
  logic [4:0]  got_rd [0:127];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog R1: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a + ~b + 32'd1;
      6'h24:   return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic bit fn_ok(input logic [5:0] fn);
    return fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25;
  endfunction

  // Sequential reference with three shadow slots after a branch.
  task automatic model(input int n);
    logic [31:0] r [32];
    logic [31:0] d [64];
    logic        tk [0:127];
    logic [31:0] tg [0:127];
    logic [31:0] pc;
    for (int i = 0; i < 32; i++) r[i] = '0;
    for (int i = 0; i < 64; i++) d[i] = dinit[i];
    pc = '0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] ins, simm, addr;
      logic [4:0]  rs, rt, rd;
      logic [5:0]  op, fn;
      exp_pc[k] = pc;
      ins  = prog[pc[7:2]];
      op   = ins[31:26]; fn = ins[5:0];
      rs   = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      simm = 32'($signed(ins[15:0]));
      exp_we[k] = 0; exp_ld[k] = 0; exp_sw[k] = 0; tk[k] = 0; tg[k] = '0;
      exp_rd[k] = '0; exp_wd[k] = '0; exp_sa[k] = '0; exp_sd[k] = '0;
      if (op == 6'h00 && fn_ok(fn)) begin
        exp_we[k] = 1; exp_rd[k] = rd; exp_wd[k] = ref_alu(fn, r[rs], r[rt]);
      end else if (op == 6'h23) begin
        addr = r[rs] + simm;
        exp_we[k] = 1; exp_ld[k] = 1; exp_rd[k] = rt; exp_wd[k] = d[addr[7:2]];
      end else if (op == 6'h2B) begin
        addr = r[rs] + simm;
        exp_sw[k] = 1; exp_sa[k] = addr; exp_sd[k] = r[rt]; d[addr[7:2]] = r[rt];
      end else if (op == 6'h04) begin
        tk[k] = (r[rs] == r[rt]); tg[k] = pc + 32'd4 + (simm << 2);
      end
      if (exp_we[k] && exp_rd[k] != 0) r[exp_rd[k]] = exp_wd[k];
      if (k >= 3 && tk[k-3]) pc = tg[k-3];
      else                   pc = pc + 32'd4;
    end
  endtask

  task automatic preload();
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_dmem = (i >= 64); ld_addr = 6'(i % 64);
      ld_data = (i >= 64) ? dinit[i-64] : prog[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    chk(pc_o == 0, "R9 pc in reset", pc_o, 0);
    chk(!wb_we_o, "R9 wb_we in reset", 32'(wb_we_o), 0);
    chk(!st_we_o, "R9 st_we in reset", 32'(st_we_o), 0);
  endtask

  task automatic run_prog(input int n);
    preload();
    model(n + 5);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 1; c <= n + 4; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk(pc_o == exp_pc[c], "R5/R1 pc", pc_o, exp_pc[c]);
      if (c >= 4) begin
        int k;
        k = c - 4;
        got_wd[k] = wb_data_o; got_rd[k] = wb_rd_o;
        chk(wb_we_o == exp_we[k], "R10/R1 wb_we", 32'(wb_we_o), 32'(exp_we[k]));
        if (exp_we[k]) begin
          chk(wb_rd_o == exp_rd[k], "R2 wb_rd", 32'(wb_rd_o), 32'(exp_rd[k]));
          chk(wb_data_o == exp_wd[k], exp_ld[k] ? "R6 load data" : "R4 alu result",
              wb_data_o, exp_wd[k]);
        end
      end else begin
        chk(!wb_we_o, "R9 early wb", 32'(wb_we_o), 0);
      end
      if (c >= 3) begin
        int k;
        k = c - 3;
        chk(st_we_o == exp_sw[k], "R7 st_we", 32'(st_we_o), 32'(exp_sw[k]));
        if (exp_sw[k]) begin
          chk(st_addr_o == exp_sa[k], "R3 store addr", st_addr_o, exp_sa[k]);
          chk(st_data_o == exp_sd[k], "R7 store data", st_data_o, exp_sd[k]);
        end
      end else begin
        chk(!st_we_o, "R9 early store", 32'(st_we_o), 0);
      end
    end
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic gen_random(input int n);
    int last1, last2;
    logic [5:0] fns [4];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25;
    last1 = 0; last2 = 0;
    for (int i = 0; i < 64; i++) begin
      prog[i] = '0;
      dinit[i] = $urandom;
    end
    for (int i = 0; i < n; i++) begin
      int kind, s1, s2, dst, off;
      kind = $urandom_range(0, 9);
      do s1 = $urandom_range(0, 31); while (s1 != 0 && (s1 == last1 || s1 == last2));
      do s2 = $urandom_range(0, 31); while (s2 != 0 && (s2 == last1 || s2 == last2));
      dst = $urandom_range(0, 31);
      off = 4 * $urandom_range(0, 63);
      if ($urandom_range(0, 3) == 0) off = -off;
      if (kind <= 3) begin
        prog[i] = enc_r(fns[kind], s1, s2, dst);
      end else if (kind <= 6) begin
        prog[i] = enc_i(6'h23, 0, dst, off);
      end else if (kind == 7) begin
        prog[i] = enc_i(6'h2B, 0, s2, off); dst = 0;
      end else if (kind == 8) begin
        prog[i] = {6'h3F, 26'($urandom)}; dst = 0;
      end else begin
        prog[i] = enc_r(6'h2A, s1, s2, dst); dst = 0;
      end
      last2 = last1; last1 = dst;
    end
  endtask

  initial begin
    void'($urandom(32'd7193));

    // Directed program: operands, register 0, bypass, stores, branches.
    for (int i = 0; i < 64; i++) begin prog[i] = '0; dinit[i] = $urandom; end
    dinit[0] = 32'h7FFF_FFFF; dinit[1] = 32'h0000_0001; dinit[63] = 32'h8000_0000;
    prog[0]  = enc_i(6'h23, 0, 1, 0);
    prog[1]  = enc_i(6'h23, 0, 2, 4);
    prog[2]  = enc_i(6'h23, 0, 3, -4);
    prog[3]  = enc_r(6'h20, 1, 1, 4);
    prog[4]  = enc_r(6'h22, 2, 1, 5);
    prog[5]  = enc_r(6'h24, 3, 1, 6);
    prog[6]  = enc_r(6'h25, 1, 2, 0);
    prog[7]  = enc_i(6'h2B, 0, 4, 8);
    prog[8]  = enc_r(6'h27, 1, 2, 15);
    prog[9]  = enc_r(6'h20, 0, 5, 7);
    prog[10] = enc_i(6'h23, 0, 8, 8);
    prog[11] = enc_r(6'h25, 6, 3, 9);
    prog[12] = enc_i(6'h04, 0, 3, 5);
    prog[13] = enc_i(6'h04, 0, 0, 6);
    prog[14] = enc_r(6'h20, 1, 2, 10);
    prog[15] = enc_r(6'h22, 2, 1, 11);
    prog[16] = enc_r(6'h24, 4, 4, 12);
    prog[17] = enc_r(6'h20, 1, 1, 13);
    prog[20] = enc_r(6'h20, 7, 0, 14);
    prog[21] = enc_i(6'h04, 0, 0, -1);
    run_prog(26);
    chk(got_wd[0] == 32'h7FFF_FFFF, "R11 preloaded word", got_wd[0], 32'h7FFF_FFFF);
    chk(got_wd[2] == 32'h8000_0000, "R3 negative offset", got_wd[2], 32'h8000_0000);
    chk(got_wd[3] == 32'hFFFF_FFFE, "R8 same-cycle read", got_wd[3], 32'hFFFF_FFFE);
    chk(got_wd[9] == 32'h8000_0002, "R8 r0 stays zero", got_wd[9], 32'h8000_0002);
    chk(got_wd[10] == 32'hFFFF_FFFE, "R7 load after store", got_wd[10], 32'hFFFF_FFFE);
    chk(got_rd[14] == 5'd10, "R5 shadow slot retires", 32'(got_rd[14]), 10);
    chk(got_rd[17] == 5'd14, "R5 target after shadows", 32'(got_rd[17]), 14);

    gen_random(40);
    run_prog(48);
    gen_random(40);
    run_prog(48);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule